// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block closes the decode stage of a five-stage in-order integer pipeline. For each of the two source operands of the instruction being decoded, it decides where the freshest copy of that register lives. The copy can be the register-file read data, the result the ALU is producing in the same cycle, or the value leaving the access stage, which is either loaded data or an ALU result passed along. The chosen value is captured in a flip-flop that feeds the ALU directly in the next cycle. The ALU therefore never waits for a register-file write and read round trip.

A producer in execute or access counts only when its stage holds a valid instruction that writes a register. A source index of zero names the hard-wired zero register and yields zero. When both downstream stages write the register being read, the instruction in execute is the younger one and wins. A hold input from the stall logic freezes both operand registers. Each operand also carries a registered 2-bit code that tells which path supplied it.

Top module: `opfwd_sel`

## Requirements
- R1: While `rst_n` is low, both operand outputs read zero and both source codes read 0 (register file).
- R2: When the execute stage is valid, writes a register, and its destination equals a nonzero source index, that operand equals `ex_result` one clock later, with source code 1.
- R3: When only the access stage is valid, writes a register, and matches a nonzero source index, that operand equals `acc_result` one clock later, with source code 2.
- R4: When both the execute and access stages match the same source index, the execute result is taken (code 1).
- R5: A stage whose valid flag or write-enable flag is 0 never supplies an operand, whatever its destination index.
- R6: When no producer matches a nonzero source index, the operand equals the register-file read data one clock later, with source code 0.
- R7: A source index of 0 gives an operand of zero with source code 3, regardless of the register-file data and of any producer naming register 0.
- R8: While `dec_hold` is high at a clock edge, both operands and both source codes keep their values.
- R9: The two operands are selected independently. Each may take a different path in the same cycle, and both may take the same producer when they name the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_hold | input | 1 | Decode stall; holds the operand registers |
| src_a_idx | input | 5 | First source register index of decoded instruction |
| src_b_idx | input | 5 | Second source register index of decoded instruction |
| rf_a_data | input | 32 | Register-file read data for first source |
| rf_b_data | input | 32 | Register-file read data for second source |
| ex_vld | input | 1 | Execute stage holds a valid instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination index |
| ex_result | input | 32 | Present ALU output |
| acc_vld | input | 1 | Access stage holds a valid instruction |
| acc_wr | input | 1 | Access-stage instruction writes a register |
| acc_dst | input | 5 | Access-stage destination index |
| acc_result | input | 32 | Present access-stage output (load data or forwarded ALU result) |
| alu_in_a | output | 32 | Registered first ALU operand |
| alu_in_b | output | 32 | Registered second ALU operand |
| alu_src_a | output | 2 | Path of first operand: 0 register file, 1 execute, 2 access, 3 zero |
| alu_src_b | output | 2 | Path of second operand, same encoding |

## Verification
Properties inside each operand lane check on every cycle that the captured value follows the prior cycle's inputs. They cover the execute path and its priority, the access-only path, the register-file fallback with gated producers, the zero register, and the hold. The reset value of the outputs and the independence of the two lanes can only be shown by the bench's scenarios. The same holds for the dependent-instruction sequence, in which a subtract writes r10 and an AND reads r10 on the next cycle. The bench also exercises the corner cases where a producer names register 0 or has only one of its two enabling flags set.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    // Producers, youngest first: index 0 is execute, index 1 is access.
    localparam int unsigned NUM_PROD = 2;

    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_EX   = 2'd1,
        SRC_ACC  = 2'd2,
        SRC_ZERO = 2'd3
    } opnd_src_e;

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             prod_vld,
    input  logic             prod_wr,
    input  logic [IDX_W-1:0] prod_dst,
    input  logic [IDX_W-1:0] src_idx,
    output logic             hit
);

    logic idx_eq;
    logic src_nonzero;

    always_comb begin
        idx_eq      = (prod_dst == src_idx);
        src_nonzero = |src_idx;
        hit         = prod_vld & prod_wr & idx_eq & src_nonzero;
    end

endmodule

// File: rtl/opfwd_lane.sv
module opfwd_lane
    import opfwd_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hold,
    input  logic [IDX_W-1:0]          src_idx,
    input  logic [XLEN-1:0]           rf_data,
    input  logic [NUM_PROD-1:0]       prod_vld,
    input  logic [NUM_PROD-1:0]       prod_wr,
    input  logic [IDX_W-1:0]          prod_dst  [NUM_PROD],
    input  logic [XLEN-1:0]           prod_data [NUM_PROD],
    output logic [XLEN-1:0]           opnd_q,
    output opnd_src_e                 src_q
);

    typedef struct packed {
        logic [XLEN-1:0] opnd;
        opnd_src_e       src;
    } lane_state_t;

    lane_state_t state_d, state_q;
    logic [NUM_PROD-1:0] hit;

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_match
        opfwd_match #(
            .IDX_W(IDX_W)
        ) u_match (
            .prod_vld (prod_vld[p]),
            .prod_wr  (prod_wr[p]),
            .prod_dst (prod_dst[p]),
            .src_idx  (src_idx),
            .hit      (hit[p])
        );
    end

    always_comb begin
        state_d = state_q;
        if (!hold) begin
            state_d.opnd = rf_data;
            state_d.src  = SRC_RF;
            // Walk from oldest to youngest so the youngest match wins.
            for (int p = NUM_PROD - 1; p >= 0; p--) begin
                if (hit[p]) begin
                    state_d.opnd = prod_data[p];
                    state_d.src  = opnd_src_e'(2'(p + 1));
                end
            end
            if (src_idx == '0) begin
                state_d.opnd = '0;
                state_d.src  = SRC_ZERO;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign opnd_q = state_q.opnd;
    assign src_q  = state_q.src;

    // Execute match takes the ALU result, even when access also matches.
    assert_ex_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hold && src_idx != '0 && prod_vld[0] && prod_wr[0]
              && prod_dst[0] == src_idx)
        |-> (opnd_q == $past(prod_data[0]) && src_q == SRC_EX));

    // Access-only match takes the access output.
    assert_acc_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hold && src_idx != '0
              && !(prod_vld[0] && prod_wr[0] && prod_dst[0] == src_idx)
              && prod_vld[1] && prod_wr[1] && prod_dst[1] == src_idx)
        |-> (opnd_q == $past(prod_data[1]) && src_q == SRC_ACC));

    // With no enabled producer, the register file supplies the operand (R5, R6).
    assert_rf_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hold && src_idx != '0
              && !(prod_vld[0] && prod_wr[0]) && !(prod_vld[1] && prod_wr[1]))
        |-> (opnd_q == $past(rf_data) && src_q == SRC_RF));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hold && src_idx == '0)
        |-> (opnd_q == '0 && src_q == SRC_ZERO));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hold) |-> ($stable(opnd_q) && $stable(src_q)));

endmodule

// File: rtl/opfwd_sel.sv
module opfwd_sel
    import opfwd_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_hold,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [XLEN-1:0]  rf_a_data,
    input  logic [XLEN-1:0]  rf_b_data,
    input  logic             ex_vld,
    input  logic             ex_wr,
    input  logic [IDX_W-1:0] ex_dst,
    input  logic [XLEN-1:0]  ex_result,
    input  logic             acc_vld,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_dst,
    input  logic [XLEN-1:0]  acc_result,
    output logic [XLEN-1:0]  alu_in_a,
    output logic [XLEN-1:0]  alu_in_b,
    output logic [1:0]       alu_src_a,
    output logic [1:0]       alu_src_b
);

    localparam int unsigned NUM_LANES = 2;

    logic [NUM_PROD-1:0] prod_vld;
    logic [NUM_PROD-1:0] prod_wr;
    logic [IDX_W-1:0]    prod_dst  [NUM_PROD];
    logic [XLEN-1:0]     prod_data [NUM_PROD];

    logic [IDX_W-1:0]    lane_idx  [NUM_LANES];
    logic [XLEN-1:0]     lane_rf   [NUM_LANES];
    logic [XLEN-1:0]     lane_opnd [NUM_LANES];
    opnd_src_e           lane_src  [NUM_LANES];

    always_comb begin
        prod_vld     = {acc_vld, ex_vld};
        prod_wr      = {acc_wr,  ex_wr};
        prod_dst[0]  = ex_dst;
        prod_dst[1]  = acc_dst;
        prod_data[0] = ex_result;
        prod_data[1] = acc_result;
        lane_idx[0]  = src_a_idx;
        lane_idx[1]  = src_b_idx;
        lane_rf[0]   = rf_a_data;
        lane_rf[1]   = rf_b_data;
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        opfwd_lane #(
            .XLEN  (XLEN),
            .IDX_W (IDX_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (dec_hold),
            .src_idx   (lane_idx[l]),
            .rf_data   (lane_rf[l]),
            .prod_vld  (prod_vld),
            .prod_wr   (prod_wr),
            .prod_dst  (prod_dst),
            .prod_data (prod_data),
            .opnd_q    (lane_opnd[l]),
            .src_q     (lane_src[l])
        );
    end

    assign alu_in_a  = lane_opnd[0];
    assign alu_in_b  = lane_opnd[1];
    assign alu_src_a = lane_src[0];
    assign alu_src_b = lane_src[1];

endmodule

// File: tb/opfwd_sel_bench.sv
module opfwd_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_hold = 1'b0;
    logic [4:0]  src_a_idx = '0, src_b_idx = '0;
    logic [31:0] rf_a_data = '0, rf_b_data = '0;
    logic        ex_vld = 1'b0, ex_wr = 1'b0, acc_vld = 1'b0, acc_wr = 1'b0;
    logic [4:0]  ex_dst = '0, acc_dst = '0;
    logic [31:0] ex_result = '0, acc_result = '0;
    logic [31:0] alu_in_a, alu_in_b;
    logic [1:0]  alu_src_a, alu_src_b;

    always #5 clk = ~clk;

    opfwd_sel u_opfwd_sel (
        .clk(clk), .rst_n(rst_n), .dec_hold(dec_hold),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .ex_vld(ex_vld), .ex_wr(ex_wr), .ex_dst(ex_dst), .ex_result(ex_result),
        .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_dst(acc_dst), .acc_result(acc_result),
        .alu_in_a(alu_in_a), .alu_in_b(alu_in_b),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  sa;
        logic [1:0]  sb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected operand and path code, written from the requirements.
    function automatic logic [33:0] model(input logic [4:0] idx, input logic [31:0] rf);
        if (idx == 5'd0)                                 return {2'd3, 32'd0};       // R7
        if (ex_vld && ex_wr && ex_dst == idx)            return {2'd1, ex_result};   // R2, R4
        if (acc_vld && acc_wr && acc_dst == idx)         return {2'd2, acc_result};  // R3
        return {2'd0, rf};                                                           // R5, R6
    endfunction

    task automatic step(input string tag, input bit hold,
                        input logic [4:0] ia, input logic [4:0] ib,
                        input logic [31:0] ra, input logic [31:0] rb,
                        input bit ev, input bit ew, input logic [4:0] ed, input logic [31:0] er,
                        input bit av, input bit aw, input logic [4:0] ad, input logic [31:0] ar);
        exp_t e;
        logic [33:0] ma, mb;
        @(negedge clk);
        dec_hold = hold; src_a_idx = ia; src_b_idx = ib; rf_a_data = ra; rf_b_data = rb;
        ex_vld = ev; ex_wr = ew; ex_dst = ed; ex_result = er;
        acc_vld = av; acc_wr = aw; acc_dst = ad; acc_result = ar;
        if (hold) begin
            e = last_exp;
        end else begin
            ma = model(ia, ra);
            mb = model(ib, rb);
            e.a = ma[31:0]; e.sa = ma[33:32];
            e.b = mb[31:0]; e.sb = mb[33:32];
        end
        e.tag = tag;
        last_exp = e;
        exp_q.push_back(e);
    endtask

    // Monitor: one item is due after each clock edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                check(e.tag, "alu_in_a",  alu_in_a, e.a);
                check(e.tag, "alu_in_b",  alu_in_b, e.b);
                check(e.tag, "alu_src_a", {30'd0, alu_src_a}, {30'd0, e.sa});
                check(e.tag, "alu_src_b", {30'd0, alu_src_b}, {30'd0, e.sb});
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        src_a_idx = 5'd3; src_b_idx = 5'd4; rf_a_data = 32'hAAAA_0001; rf_b_data = 32'hBBBB_0002;
        ex_vld = 1'b1; ex_wr = 1'b1; ex_dst = 5'd3; ex_result = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "alu_in_a",  alu_in_a, 32'd0);
        check("R1", "alu_in_b",  alu_in_b, 32'd0);
        check("R1", "alu_src_a", {30'd0, alu_src_a}, 32'd0);
        check("R1", "alu_src_b", {30'd0, alu_src_b}, 32'd0);
        last_exp.a = '0; last_exp.b = '0; last_exp.sa = '0; last_exp.sb = '0; last_exp.tag = "R1";
        @(negedge clk);
        rst_n = 1'b1;

        // R6: no producers
        step("R6", 0, 5'd5, 5'd7, 32'h0000_0505, 32'h0000_0707,
             0, 0, 5'd0, 32'h0, 0, 0, 5'd0, 32'h0);
        // R2: SUB writing r10 in execute, AND reading r10 (second operand immediate-like r0, R7)
        step("R2", 0, 5'd10, 5'd0, 32'hDEAD_0010, 32'hFFFF_FFFF,
             1, 1, 5'd10, 32'h0000_0F0E, 0, 0, 5'd0, 32'h0);
        // R3: access only match on second operand
        step("R3", 0, 5'd9, 5'd4, 32'h0000_0909, 32'h0000_0404,
             1, 1, 5'd11, 32'h1111_1111, 1, 1, 5'd4, 32'h4444_4444);
        // R4: both stages write r6
        step("R4", 0, 5'd6, 5'd6, 32'h0606_0606, 32'h0606_0606,
             1, 1, 5'd6, 32'hE0E0_E0E0, 1, 1, 5'd6, 32'hACAC_ACAC);
        // R5: matching producers but gated off by a flag
        step("R5", 0, 5'd8, 5'd8, 32'h0808_0001, 32'h0808_0002,
             1, 0, 5'd8, 32'hBAD0_0001, 0, 1, 5'd8, 32'hBAD0_0002);
        step("R5", 0, 5'd8, 5'd8, 32'h0808_0003, 32'h0808_0004,
             0, 1, 5'd8, 32'hBAD0_0003, 1, 0, 5'd8, 32'hBAD0_0004);
        // R7: register 0 with producers naming r0
        step("R7", 0, 5'd0, 5'd0, 32'h7777_7777, 32'h8888_8888,
             1, 1, 5'd0, 32'hBAD0_0005, 1, 1, 5'd0, 32'hBAD0_0006);
        // R9: different paths per lane, then same producer for both
        step("R9", 0, 5'd12, 5'd13, 32'h0C0C_0C0C, 32'h0D0D_0D0D,
             1, 1, 5'd12, 32'h1200_0012, 1, 1, 5'd13, 32'h1300_0013);
        step("R9", 0, 5'd14, 5'd14, 32'h0E0E_0E0E, 32'h0E0E_0E0E,
             1, 1, 5'd14, 32'h1400_0014, 0, 0, 5'd0, 32'h0);
        // R8: hold for two cycles with changing inputs
        step("R8", 1, 5'd1, 5'd2, 32'h0101_0101, 32'h0202_0202,
             1, 1, 5'd1, 32'hBAD0_0007, 1, 1, 5'd2, 32'hBAD0_0008);
        step("R8", 1, 5'd0, 5'd0, 32'h0303_0303, 32'h0404_0404,
             0, 0, 5'd0, 32'h0, 0, 0, 5'd0, 32'h0);
        // release: capture resumes (R6, R3)
        step("R6", 0, 5'd21, 5'd22, 32'h2121_2121, 32'h2222_2222,
             0, 0, 5'd21, 32'h0, 1, 1, 5'd22, 32'h2200_0022);

        @(negedge clk);
        dec_hold = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule